// File: doc/BRIEF.md
# Locked Read-Modify-Write Guard

This block sits beside the instruction decoder and the bus interface of an x86-style core. Each decoded instruction arrives as a descriptor with a valid strobe. The descriptor carries a lock-prefix flag, a class code and the destination type taken from the addressing-mode field. When the lock prefix is present, the block decides whether the lock is legal. A lock is legal only for a read-modify-write class whose result goes to memory. A legal lock starts an atomic sequence. An illegal lock raises an invalid-opcode exception pulse. Descriptors without a lock prefix pass through untouched.

During a legal locked sequence the block drives a bus-lock signal. It also arbitrates a set of external bus masters, for example a peripheral bridge, so that none of them is granted the bus between the locked read and the final write. A grant that is already active when the lock is accepted is allowed to finish first. The locked read is released only once that grant is gone. Requests that arrive during the lock wait, and one of them is granted as soon as the lock drops.

Top module: `rmw_lock_guard`

## Requirements
- R1: Class codes 1 to 17 are the lockable read-modify-write classes: bit test and modify (1-3), exchange family (4-6), single-operand arithmetic and logic (7-10), two-operand arithmetic and logic (11-17). A locked descriptor with one of these classes and destination code 1 (memory) raises no exception. When no external grant is active, `rmw_rd_go` is high in the cycle after the valid strobe.
- R2: A locked descriptor whose class code is 0 or 18 to 31 raises `inv_op_exc` in the cycle after its valid strobe, for exactly one cycle.
- R3: A locked descriptor with a lockable class but destination code 0 (register), 2 (I/O) or 3 (reserved) also raises `inv_op_exc` in the cycle after its valid strobe.
- R4: When an exception is raised, the instruction never gets `rmw_rd_go`, and `bus_lock` stays low.
- R5: A descriptor without the lock prefix never raises an exception and never starts a locked sequence.
- R6: `bus_lock` rises in the cycle `rmw_rd_go` is high. It stays high through the cycle in which `rmw_wr_done` is sampled high and through the cycle after that, and it is low in the cycle after that.
- R7: An external request raised during a locked sequence is not granted while `bus_lock` is high. It is granted in the first cycle in which `bus_lock` is low.
- R8: If an external grant is active when a lock is accepted, `rmw_rd_go` and `bus_lock` stay low until that master drops its request. `rmw_rd_go` then rises in the cycle after the request is sampled low.
- R9: `ext_gnt` is one-hot or zero and is never high together with `bus_lock`. An idle request is granted in the next cycle, with the lowest index winning. A grant holds while its request stays high. A lock accepted in the same cycle as a new request wins over that request.
- R10: Descriptors presented while a locked sequence is in progress are ignored: they raise no exception and start no second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Descriptor valid strobe |
| ins_lock | input | 1 | Lock prefix present |
| ins_class | input | CLASS_W | Instruction class code |
| ins_dest | input | 2 | Destination: 0 register, 1 memory, 2 I/O, 3 reserved |
| rmw_wr_done | input | 1 | Final write of the locked sequence completes |
| ext_req | input | N_EXT | External master bus requests |
| inv_op_exc | output | 1 | Invalid-opcode exception pulse |
| rmw_rd_go | output | 1 | Locked read may start this cycle |
| bus_lock | output | 1 | Bus locked for the atomic sequence |
| ext_gnt | output | N_EXT | External master grants |

## Verification
A sequencer stuck in a busy state shows at the ports in the next descriptor's cycle. That descriptor then gets neither an exception nor `rmw_rd_go`, and idle requests go ungranted. A legality decode that is off by one class or one destination code gives a wrong `inv_op_exc` one cycle after the strobe. A grant path that ignores the lock shows `ext_gnt` high beside `bus_lock` in the same cycle. A release that is one cycle early or late shows as a misplaced fall of `bus_lock` or a misplaced rise of the pending grant, two cycles after `rmw_wr_done`.

// File: rtl/rlg_pkg.sv
// Package: shared encodings for the locked read-modify-write guard.
// Assumes: class codes are assigned by the decoder as listed below.
package rlg_pkg;

    // Destination type from the addressing-mode field
    typedef enum logic [1:0] {
        DEST_REG  = 2'd0,
        DEST_MEM  = 2'd1,
        DEST_IO   = 2'd2,
        DEST_RSVD = 2'd3
    } dest_e;

    // Sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WAIT   = 2'd1,
        SQ_LOCKED = 2'd2,
        SQ_TAIL   = 2'd3
    } seq_e;

    // Lockable class codes; every other code is not lockable
    localparam int CLS_BTS     = 1;
    localparam int CLS_BTR     = 2;
    localparam int CLS_BTC     = 3;
    localparam int CLS_XADD    = 4;
    localparam int CLS_XCHG    = 5;
    localparam int CLS_CMPXCHG = 6;
    localparam int CLS_DEC     = 7;
    localparam int CLS_INC     = 8;
    localparam int CLS_NEG     = 9;
    localparam int CLS_NOT     = 10;
    localparam int CLS_ADC     = 11;
    localparam int CLS_ADD     = 12;
    localparam int CLS_AND     = 13;
    localparam int CLS_OR      = 14;
    localparam int CLS_SBB     = 15;
    localparam int CLS_SUB     = 16;
    localparam int CLS_XOR     = 17;

    localparam int LOCKABLE_LO = CLS_BTS;
    localparam int LOCKABLE_HI = CLS_XOR;

endpackage

// File: rtl/rlg_legality.sv
// Module: rlg_legality
// Decides whether a locked descriptor is legal. It emits an accept strobe
// (combinational) and a registered exception pulse. Descriptors are only
// evaluated while the sequencer is idle (R10).
// Assumes: CLASS_W is wide enough to hold LOCKABLE_HI.
module rlg_legality
    import rlg_pkg::*;
#(
    parameter int CLASS_W = 5,
    parameter int CLS_LO  = LOCKABLE_LO,
    parameter int CLS_HI  = LOCKABLE_HI
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic               ins_lock,
    input  logic [CLASS_W-1:0] ins_class,
    input  logic [1:0]         ins_dest,
    input  logic               seq_idle,
    output logic               accept,
    output logic               exc_q
);

    localparam logic [CLASS_W-1:0] LO_C = CLASS_W'(CLS_LO);
    localparam logic [CLASS_W-1:0] HI_C = CLASS_W'(CLS_HI);

    logic listed;
    logic to_mem;
    logic evaluated;
    logic reject;

    // Classify the descriptor against the lockable set and destination
    always_comb begin
        listed    = (ins_class >= LO_C) && (ins_class <= HI_C);
        to_mem    = (ins_dest == DEST_MEM);
        evaluated = ins_valid && ins_lock && seq_idle;
        accept    = evaluated && listed && to_mem;
        reject    = evaluated && !(listed && to_mem);
    end

    // Register the exception as a one-cycle pulse per rejected strobe
    always_ff @(posedge clk) begin
        if (!rst_n) exc_q <= 1'b0;
        else        exc_q <= reject;
    end

endmodule

// File: rtl/rlg_sequencer.sv
// Module: rlg_sequencer
// Runs the locked sequence: wait for the external grant to clear, release
// the locked read, hold the lock until the final write, then keep it one
// more cycle.
// Assumes: rmw_wr_done is only meaningful after the read was released.
module rlg_sequencer
    import rlg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic ext_busy,
    input  logic wr_done,
    output logic seq_idle,
    output logic seq_tail,
    output logic rd_go,
    output logic bus_lock
);

    seq_e state_q;
    seq_e state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (accept)    state_d = SQ_WAIT;
            SQ_WAIT:   if (!ext_busy) state_d = SQ_LOCKED;
            SQ_LOCKED: if (wr_done)   state_d = SQ_TAIL;
            SQ_TAIL:                  state_d = SQ_IDLE;
            default:                  state_d = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from state and the external-busy flag
    always_comb begin
        seq_idle = (state_q == SQ_IDLE);
        seq_tail = (state_q == SQ_TAIL);
        rd_go    = (state_q == SQ_WAIT) && !ext_busy;
        bus_lock = rd_go || (state_q == SQ_LOCKED) || (state_q == SQ_TAIL);
    end

endmodule

// File: rtl/rlg_ext_arbiter.sv
// Module: rlg_ext_arbiter
// Fixed-priority arbiter for external masters. The lowest index wins, and a
// grant is held while its request stays high. New grants are given only
// when allow_new is high and no grant is active.
// Assumes: a master drops its request when its transfer ends.
module rlg_ext_arbiter #(
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_req,
    input  logic             allow_new,
    output logic [N_EXT-1:0] ext_gnt,
    output logic             ext_busy
);

    logic [N_EXT-1:0] pick;
    logic [N_EXT-1:0] gnt_q;

    // Pick the lowest-index request
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N_EXT; i++) begin
            if (ext_req[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign ext_busy = |gnt_q;
    assign ext_gnt  = gnt_q;

    // One grant flop per master: hold while requesting, or take a new pick
    for (genvar g = 0; g < N_EXT; g++) begin : gen_gnt
        always_ff @(posedge clk) begin
            if (!rst_n) gnt_q[g] <= 1'b0;
            else        gnt_q[g] <= ext_req[g] &&
                                    (gnt_q[g] || (pick[g] && allow_new && !ext_busy));
        end
    end

endmodule

// File: rtl/rmw_lock_guard.sv
// Module: rmw_lock_guard (top)
// Checks lock-prefix legality, raises the invalid-opcode pulse, runs the
// locked sequence and keeps external masters off the bus while it runs.
// Assumes: the decoder presents one descriptor per valid strobe.
module rmw_lock_guard
    import rlg_pkg::*;
#(
    parameter int CLASS_W = 5,
    parameter int N_EXT   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic               ins_lock,
    input  logic [CLASS_W-1:0] ins_class,
    input  logic [1:0]         ins_dest,
    input  logic               rmw_wr_done,
    input  logic [N_EXT-1:0]   ext_req,
    output logic               inv_op_exc,
    output logic               rmw_rd_go,
    output logic               bus_lock,
    output logic [N_EXT-1:0]   ext_gnt
);

    logic accept;
    logic seq_idle;
    logic seq_tail;
    logic ext_busy;
    logic allow_new;

    // New external grants only when idle with no lock taken, or in the tail
    always_comb begin
        allow_new = (seq_idle && !accept) || seq_tail;
    end

    rlg_legality #(
        .CLASS_W (CLASS_W)
    ) u_legality (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_lock  (ins_lock),
        .ins_class (ins_class),
        .ins_dest  (ins_dest),
        .seq_idle  (seq_idle),
        .accept    (accept),
        .exc_q     (inv_op_exc)
    );

    rlg_sequencer u_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .ext_busy (ext_busy),
        .wr_done  (rmw_wr_done),
        .seq_idle (seq_idle),
        .seq_tail (seq_tail),
        .rd_go    (rmw_rd_go),
        .bus_lock (bus_lock)
    );

    rlg_ext_arbiter #(
        .N_EXT (N_EXT)
    ) u_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_req   (ext_req),
        .allow_new (allow_new),
        .ext_gnt   (ext_gnt),
        .ext_busy  (ext_busy)
    );

endmodule

// File: rtl/rlg_checker.sv
// Module: rlg_checker
// Property checks on the ports of rmw_lock_guard, attached by bind.
module rlg_checker #(
    parameter int N_EXT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_lock,
    input logic             rmw_wr_done,
    input logic [N_EXT-1:0] ext_req,
    input logic             inv_op_exc,
    input logic             rmw_rd_go,
    input logic             bus_lock,
    input logic [N_EXT-1:0] ext_gnt
);

    AST_EXC_FROM_LOCKED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_op_exc |-> $past(ins_valid && ins_lock)); // R2

    AST_EXC_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        inv_op_exc |-> (!bus_lock && !rmw_rd_go)); // R4

    AST_PLAIN_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_lock) |=> !inv_op_exc); // R5

    AST_READ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_rd_go |-> bus_lock); // R6

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> $past(rmw_wr_done, 2)); // R6

    AST_NO_GNT_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> (ext_gnt == '0)); // R7

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_gnt)); // R9

    for (genvar g = 0; g < N_EXT; g++) begin : gen_hold
        AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_gnt[g] && ext_req[g]) |=> ext_gnt[g]); // R9
    end

endmodule

bind rmw_lock_guard rlg_checker #(.N_EXT(N_EXT)) u_rlg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .ins_lock    (ins_lock),
    .rmw_wr_done (rmw_wr_done),
    .ext_req     (ext_req),
    .inv_op_exc  (inv_op_exc),
    .rmw_rd_go   (rmw_rd_go),
    .bus_lock    (bus_lock),
    .ext_gnt     (ext_gnt)
);

// File: tb/test_rmw_lock_guard.sv
`timescale 1ns/1ps
module test_rmw_lock_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_valid = 1'b0;
    logic       ins_lock = 1'b0;
    logic [4:0] ins_class = '0;
    logic [1:0] ins_dest = '0;
    logic       rmw_wr_done = 1'b0;
    logic [1:0] ext_req = '0;
    logic       inv_op_exc;
    logic       rmw_rd_go;
    logic       bus_lock;
    logic [1:0] ext_gnt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rmw_lock_guard #(.CLASS_W(5), .N_EXT(2)) i_rmw_lock_guard (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_lock(ins_lock),
        .ins_class(ins_class), .ins_dest(ins_dest), .rmw_wr_done(rmw_wr_done),
        .ext_req(ext_req), .inv_op_exc(inv_op_exc), .rmw_rd_go(rmw_rd_go),
        .bus_lock(bus_lock), .ext_gnt(ext_gnt)
    );

    // {lock, class[4:0], dest[1:0], expected exception}
    localparam logic [8:0] VEC [12] = '{
        {1'b1, 5'd1,  2'd1, 1'b0},
        {1'b1, 5'd17, 2'd1, 1'b0},
        {1'b1, 5'd9,  2'd1, 1'b0},
        {1'b1, 5'd0,  2'd1, 1'b1},
        {1'b1, 5'd18, 2'd1, 1'b1},
        {1'b1, 5'd31, 2'd1, 1'b1},
        {1'b1, 5'd12, 2'd0, 1'b1},
        {1'b1, 5'd5,  2'd2, 1'b1},
        {1'b1, 5'd3,  2'd3, 1'b1},
        {1'b0, 5'd0,  2'd0, 1'b0},
        {1'b0, 5'd12, 2'd1, 1'b0},
        {1'b1, 5'd14, 2'd1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic lk, input logic [4:0] cls, input logic [1:0] dst);
        ins_valid = 1'b1; ins_lock = lk; ins_class = cls; ins_dest = dst;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset exc", {31'd0, inv_op_exc}, 0);
        chk("reset bus_lock", {31'd0, bus_lock}, 0);
        chk("reset rd_go", {31'd0, rmw_rd_go}, 0);
        chk("reset gnt", {30'd0, ext_gnt}, 0);

        // Vector walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < 12; k++) begin
            logic [8:0] v;
            logic go;
            v = VEC[k];
            go = v[8] & ~v[0];
            drive(v[8], v[7:3], v[2:1]);
            @(negedge clk);
            ins_valid = 1'b0;
            chk(v[0] ? "R2 R3 exception raised" : "R1 R5 no exception", {31'd0, inv_op_exc}, {31'd0, v[0]});
            chk("R1 R4 rd_go after strobe", {31'd0, rmw_rd_go}, {31'd0, go});
            chk("R4 R6 bus_lock with read", {31'd0, bus_lock}, {31'd0, go});
            if (go) begin
                @(negedge clk);
                chk("R6 lock held before write", {31'd0, bus_lock}, 1);
                chk("R6 read single cycle", {31'd0, rmw_rd_go}, 0);
                rmw_wr_done = 1'b1;
                @(negedge clk);
                rmw_wr_done = 1'b0;
                chk("R6 lock held after write", {31'd0, bus_lock}, 1);
                @(negedge clk);
                chk("R6 lock released", {31'd0, bus_lock}, 0);
            end else begin
                @(negedge clk);
                chk("R2 single-cycle pulse", {31'd0, inv_op_exc}, 0);
                chk("R4 R5 no lock later", {31'd0, bus_lock}, 0);
                chk("R4 R5 no read later", {31'd0, rmw_rd_go}, 0);
            end
        end

        // R8: active grant delays the locked read
        ext_req = 2'b01;
        @(negedge clk);
        chk("R9 idle grant", {30'd0, ext_gnt}, 2'b01);
        drive(1'b1, 5'd12, 2'd1);
        @(negedge clk);
        ins_valid = 1'b0;
        chk("R8 read held by grant", {31'd0, rmw_rd_go}, 0);
        chk("R8 lock held off", {31'd0, bus_lock}, 0);
        chk("R8 grant kept", {30'd0, ext_gnt}, 2'b01);
        @(negedge clk);
        chk("R8 still waiting", {31'd0, rmw_rd_go}, 0);
        ext_req = 2'b00;
        @(negedge clk);
        chk("R8 grant cleared", {30'd0, ext_gnt}, 0);
        chk("R8 read released", {31'd0, rmw_rd_go}, 1);
        chk("R8 lock rises with read", {31'd0, bus_lock}, 1);

        // R7 pending request, R10 ignored descriptors
        @(negedge clk);
        ext_req = 2'b10;
        drive(1'b1, 5'd0, 2'd1);
        @(negedge clk);
        drive(1'b1, 5'd5, 2'd1);
        chk("R10 illegal ignored during lock", {31'd0, inv_op_exc}, 0);
        chk("R7 no grant during lock", {30'd0, ext_gnt}, 0);
        @(negedge clk);
        ins_valid = 1'b0;
        chk("R10 second lock ignored", {31'd0, inv_op_exc}, 0);
        rmw_wr_done = 1'b1;
        @(negedge clk);
        rmw_wr_done = 1'b0;
        chk("R7 lock tail", {31'd0, bus_lock}, 1);
        chk("R7 no grant in tail", {30'd0, ext_gnt}, 0);
        @(negedge clk);
        chk("R7 lock dropped", {31'd0, bus_lock}, 0);
        chk("R7 pending granted", {30'd0, ext_gnt}, 2'b10);
        chk("R10 no second read", {31'd0, rmw_rd_go}, 0);
        @(negedge clk);
        chk("R10 no second sequence", {31'd0, bus_lock}, 0);
        ext_req = 2'b00;
        @(negedge clk);
        chk("R9 grant released", {30'd0, ext_gnt}, 0);

        // R9 priority and hold
        ext_req = 2'b11;
        @(negedge clk);
        chk("R9 lowest index wins", {30'd0, ext_gnt}, 2'b01);
        @(negedge clk);
        chk("R9 grant held", {30'd0, ext_gnt}, 2'b01);
        ext_req = 2'b10;
        @(negedge clk);
        chk("R9 released grant", {30'd0, ext_gnt}, 0);
        @(negedge clk);
        chk("R9 next master", {30'd0, ext_gnt}, 2'b10);
        ext_req = 2'b00;
        @(negedge clk);

        // R9 lock wins over a same-cycle new request
        ext_req = 2'b01;
        drive(1'b1, 5'd7, 2'd1);
        @(negedge clk);
        ins_valid = 1'b0;
        chk("R9 lock beats new request", {30'd0, ext_gnt}, 0);
        chk("R9 read released", {31'd0, rmw_rd_go}, 1);
        @(negedge clk);
        rmw_wr_done = 1'b1;
        @(negedge clk);
        rmw_wr_done = 1'b0;
        @(negedge clk);
        chk("R7 request granted after lock", {30'd0, ext_gnt}, 2'b01);
        ext_req = 2'b00;
        @(negedge clk);

        // R5 plain descriptor during a grant
        ext_req = 2'b10;
        @(negedge clk);
        drive(1'b0, 5'd12, 2'd1);
        @(negedge clk);
        ins_valid = 1'b0;
        chk("R5 plain passes", {31'd0, inv_op_exc}, 0);
        chk("R5 grant untouched", {30'd0, ext_gnt}, 2'b10);
        chk("R5 no lock", {31'd0, bus_lock}, 0);
        ext_req = 2'b00;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule